// File: doc/BRIEF.md
# Downspread Modulation Profile Generator

This block generates the frequency-offset word that drives a fractional divider or a digitally controlled oscillator when spread-spectrum clocking is used. The offset is an unsigned amount that is subtracted from the nominal frequency. It rises from zero to a peak and falls back again in a symmetric triangle. As a result the synthesized clock only ever moves downward from its nominal value: zero offset means exactly nominal, and the peak offset means nominal minus the selected spread depth.

The sweep advances one step on each internal tick. A tick is produced every `TICK_DIV` reference cycles, and a full period takes `2*HALF_STEPS` ticks. With the default parameters and a 14.318 MHz reference, one period is 448 cycles, which gives about 31.96 kHz. The offset LSB is 2^-20 of the nominal frequency. The default step sizes (196, 326, 490) give peaks of about 0.598 %, 0.995 % and 1.495 %. A two-bit code picks the depth, and an active-low pin enables spreading.

When spreading is turned off mid-sweep, the offset walks back to zero at the normal step rate rather than jumping. A second offset output serves the interrupt-controller clock domain and is gated by a configuration bit. A flag marks the leg in which the offset is growing, which is the leg where the frequency is falling.

Top module: `ssc_downspread_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, `core_ofs`, `apic_ofs` and `sweep_fall` are all zero.
- R2: With `spread_n` low and a fixed code, tick t (one tick per `TICK_DIV` cycles after reset release) gives offset `p*STEP` for p = t mod 2H when p <= H, and `(2H-p)*STEP` otherwise (H = `HALF_STEPS`). The value after tick t appears at the outputs from reference cycle `t*TICK_DIV+1` counted from reset release.
- R3: The step per tick is selected by `depth_sel`: 2'b00 gives `STEP_LO`, 2'b01 gives `STEP_MID` and 2'b10 gives `STEP_HI`. The peak offset is therefore H times the step.
- R4: Code 2'b11 is reserved and gives a step of zero, so the offset stays zero.
- R5: While `spread_n` is high and the offset is zero, the offset stays zero. A sweep starts on the first tick after `spread_n` falls.
- R6: If `spread_n` goes high while the offset is growing, the offset drops by one step per tick until it reaches zero, then stays there.
- R7: `depth_sel` is sampled only when a period starts from zero offset. A change during a sweep takes effect at the next period.
- R8: `sweep_fall` is high exactly while the offset is growing, which is phases p = 1 .. H-1 of a period. It rises only from zero offset.
- R9: `apic_ofs` equals `core_ofs` when `apic_en` is high and is zero when it is low. The gating has one cycle of latency.
- R10: The offset never exceeds `STEP_HI*HALF_STEPS`, and it never changes by more than `STEP_HI` between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| spread_n | input | 1 | Spread enable, active low |
| depth_sel | input | 2 | Spread depth code |
| apic_en | input | 1 | Apply the offset to the interrupt-controller clock domain too |
| core_ofs | output | OFS_W | Downward offset for the processor and bus clock domains |
| apic_ofs | output | OFS_W | Downward offset for the interrupt-controller clock domain |
| sweep_fall | output | 1 | High while the offset grows (frequency falling) |

## Verification
The bench builds the block with `OFS_W=8`, `HALF_STEPS=4`, `TICK_DIV=3` and steps of 3, 5 and 8. With these values a whole period is only 24 cycles, so several complete triangles, both turnarounds and the restart from zero can be checked tick by tick. The short legs also bring the corner cases within a few ticks: disabling in the middle of a leg, a depth change that must wait for the next period, and enabling after an idle stretch. The peak of 32 still leaves headroom in the 8-bit word, so the bound and step-size properties are checked against real values.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    DEPTH_LO   = 2'b00,
    DEPTH_MID  = 2'b01,
    DEPTH_HI   = 2'b10,
    DEPTH_RSVD = 2'b11
  } depth_e;

  typedef enum logic [1:0] {
    RAMP_IDLE = 2'b00,
    RAMP_FALL = 2'b01,
    RAMP_RISE = 2'b10
  } ramp_e;

endpackage

// File: rtl/ssc_tick_gen.sv
module ssc_tick_gen #(
  parameter int TICK_DIV = 7
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = $clog2(TICK_DIV + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/ssc_depth_map.sv
module ssc_depth_map
  import ssc_pkg::*;
#(
  parameter int OFS_W    = 16,
  parameter int STEP_LO  = 196,
  parameter int STEP_MID = 326,
  parameter int STEP_HI  = 490
) (
  input  depth_e             sel,
  output logic [OFS_W-1:0]   step
);
  always_comb begin
    case (sel)
      DEPTH_LO:  step = OFS_W'(STEP_LO);
      DEPTH_MID: step = OFS_W'(STEP_MID);
      DEPTH_HI:  step = OFS_W'(STEP_HI);
      default:   step = '0;
    endcase
  end
endmodule

// File: rtl/ssc_ramp.sv
module ssc_ramp
  import ssc_pkg::*;
#(
  parameter int OFS_W      = 16,
  parameter int HALF_STEPS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [OFS_W-1:0] step_in,
  output logic [OFS_W-1:0] acc,
  output logic             fall
);
  localparam int HS_W = $clog2(HALF_STEPS + 1);
  localparam logic [HS_W-1:0] LAST_STEP = HS_W'(HALF_STEPS - 1);
  localparam ramp_e FIRST_LEG = (HALF_STEPS == 1) ? RAMP_RISE : RAMP_FALL;

  ramp_e            state;
  logic [OFS_W-1:0] step_q;
  logic [HS_W-1:0]  leg_cnt;
  logic             at_floor;

  // one step above zero: the next downward step lands exactly on zero
  assign at_floor = (acc == step_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RAMP_IDLE;
      acc     <= '0;
      step_q  <= '0;
      leg_cnt <= '0;
    end else if (tick) begin
      case (state)
        RAMP_IDLE: begin
          if (en) begin
            step_q  <= step_in;
            acc     <= step_in;
            leg_cnt <= HS_W'(1);
            state   <= FIRST_LEG;
          end
        end
        RAMP_FALL: begin
          if (!en) begin
            acc   <= acc - step_q;
            state <= at_floor ? RAMP_IDLE : RAMP_RISE;
          end else begin
            acc     <= acc + step_q;
            leg_cnt <= leg_cnt + 1'b1;
            if (leg_cnt == LAST_STEP) state <= RAMP_RISE;
          end
        end
        RAMP_RISE: begin
          acc <= acc - step_q;
          if (at_floor) state <= RAMP_IDLE;
        end
        default: state <= RAMP_IDLE;
      endcase
    end
  end

  assign fall = (state == RAMP_FALL);
endmodule

// File: rtl/ssc_downspread_gen.sv
module ssc_downspread_gen
  import ssc_pkg::*;
#(
  parameter int OFS_W      = 16,
  parameter int HALF_STEPS = 32,
  parameter int TICK_DIV   = 7,
  parameter int STEP_LO    = 196,
  parameter int STEP_MID   = 326,
  parameter int STEP_HI    = 490
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spread_n,
  input  logic [1:0]       depth_sel,
  input  logic             apic_en,
  output logic [OFS_W-1:0] core_ofs,
  output logic [OFS_W-1:0] apic_ofs,
  output logic             sweep_fall
);
  logic             tick;
  logic [OFS_W-1:0] step_sel;
  logic [OFS_W-1:0] acc;
  logic             fall;

  ssc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  ssc_depth_map #(
    .OFS_W    (OFS_W),
    .STEP_LO  (STEP_LO),
    .STEP_MID (STEP_MID),
    .STEP_HI  (STEP_HI)
  ) u_map (
    .sel  (depth_e'(depth_sel)),
    .step (step_sel)
  );

  ssc_ramp #(
    .OFS_W      (OFS_W),
    .HALF_STEPS (HALF_STEPS)
  ) u_ramp (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .en      (~spread_n),
    .step_in (step_sel),
    .acc     (acc),
    .fall    (fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_ofs   <= '0;
      apic_ofs   <= '0;
      sweep_fall <= 1'b0;
    end else begin
      core_ofs   <= acc;
      apic_ofs   <= apic_en ? acc : '0;
      sweep_fall <= fall;
    end
  end
endmodule

// File: rtl/ssc_downspread_chk.sv
module ssc_downspread_chk #(
  parameter int OFS_W      = 16,
  parameter int HALF_STEPS = 32,
  parameter int STEP_HI    = 490
) (
  input logic             clk,
  input logic             rst,
  input logic             spread_n,
  input logic [OFS_W-1:0] core_ofs,
  input logic [OFS_W-1:0] apic_ofs,
  input logic             sweep_fall
);
  localparam logic [OFS_W-1:0] PEAK_MAX = OFS_W'(STEP_HI * HALF_STEPS);
  localparam logic [OFS_W-1:0] STEP_MAX = OFS_W'(STEP_HI);

  a_r10_peak_bound: assert property (@(posedge clk) disable iff (rst)
    core_ofs <= PEAK_MAX);

  a_r10_step_up: assert property (@(posedge clk) disable iff (rst)
    (core_ofs > $past(core_ofs)) |-> (core_ofs - $past(core_ofs) <= STEP_MAX));

  a_r10_step_down: assert property (@(posedge clk) disable iff (rst)
    (core_ofs < $past(core_ofs)) |-> ($past(core_ofs) - core_ofs <= STEP_MAX));

  a_r9_apic_match: assert property (@(posedge clk) disable iff (rst)
    (apic_ofs != '0) |-> (apic_ofs == core_ofs));

  a_r5_no_growth_when_off: assert property (@(posedge clk) disable iff (rst)
    $past(spread_n, 2) |-> (core_ofs <= $past(core_ofs)));

  a_r8_fall_grows: assert property (@(posedge clk) disable iff (rst)
    sweep_fall |-> (core_ofs >= $past(core_ofs)));

  a_r8_start_from_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(sweep_fall) |-> ($past(core_ofs) == '0));
endmodule

bind ssc_downspread_gen ssc_downspread_chk #(
  .OFS_W      (OFS_W),
  .HALF_STEPS (HALF_STEPS),
  .STEP_HI    (STEP_HI)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .spread_n   (spread_n),
  .core_ofs   (core_ofs),
  .apic_ofs   (apic_ofs),
  .sweep_fall (sweep_fall)
);

// File: tb/test_ssc_downspread_gen.sv
module test_ssc_downspread_gen;
  localparam int W  = 8;
  localparam int H  = 4;
  localparam int D  = 3;
  localparam int S0 = 3;
  localparam int S1 = 5;
  localparam int S2 = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         spread_n = 1'b1;
  logic [1:0]   depth_sel = 2'b00;
  logic         apic_en = 1'b1;
  logic [W-1:0] core_ofs;
  logic [W-1:0] apic_ofs;
  logic         sweep_fall;

  int n_tests = 0;
  int n_fail  = 0;
  int n_edge;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) n_edge <= 0;
    else     n_edge <= n_edge + 1;
  end

  ssc_downspread_gen #(
    .OFS_W(W), .HALF_STEPS(H), .TICK_DIV(D),
    .STEP_LO(S0), .STEP_MID(S1), .STEP_HI(S2)
  ) i_ssc_downspread_gen (
    .clk(clk), .rst(rst), .spread_n(spread_n), .depth_sel(depth_sel),
    .apic_en(apic_en), .core_ofs(core_ofs), .apic_ofs(apic_ofs),
    .sweep_fall(sweep_fall)
  );

  function automatic int tri_val(int t, int s);
    int p = t % (2 * H);
    return (p <= H) ? p * s : (2 * H - p) * s;
  endfunction

  function automatic int tri_fall(int t);
    int p = t % (2 * H);
    return (p >= 1 && p <= H - 1) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, n_edge);
    end
  endtask

  task automatic start(logic [1:0] code, logic en_n, logic ap);
    @(negedge clk);
    rst = 1'b1;
    depth_sel = code;
    spread_n = en_n;
    apic_en = ap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // wait until the outputs show the state after tick t
  task automatic at_tick(int t);
    while (n_edge < t * D + 1) @(negedge clk);
  endtask

  task automatic t_reset;
    start(2'b00, 1'b0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 core in reset", int'(core_ofs), 0);
    check("R1 flag in reset", int'(sweep_fall), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 core after release", int'(core_ofs), 0);
    check("R1 apic after release", int'(apic_ofs), 0);
  endtask

  task automatic t_profile(logic [1:0] code, int s);
    start(code, 1'b0, 1'b1);
    for (int t = 0; t <= 4 * H; t++) begin
      at_tick(t);
      check("R2 R3 triangle offset", int'(core_ofs), tri_val(t, s));
      check("R9 apic follows", int'(apic_ofs), tri_val(t, s));
      check("R8 falling flag", int'(sweep_fall), tri_fall(t));
    end
  endtask

  task automatic t_reserved;
    start(2'b11, 1'b0, 1'b1);
    for (int t = 0; t <= 2 * H + 1; t++) begin
      at_tick(t);
      check("R4 reserved code zero", int'(core_ofs), 0);
    end
  endtask

  task automatic t_disabled;
    start(2'b10, 1'b1, 1'b1);
    for (int t = 0; t <= 5; t++) begin
      at_tick(t);
      check("R5 off stays zero", int'(core_ofs), 0);
      check("R5 off no flag", int'(sweep_fall), 0);
    end
    spread_n = 1'b0;
    at_tick(6);
    check("R5 start after enable", int'(core_ofs), S2);
    at_tick(7);
    check("R5 second step", int'(core_ofs), 2 * S2);
  endtask

  task automatic t_midoff;
    start(2'b01, 1'b0, 1'b1);
    at_tick(2);
    check("R6 before disable", int'(core_ofs), 2 * S1);
    spread_n = 1'b1;
    at_tick(3);
    check("R6 ramp back one step", int'(core_ofs), S1);
    check("R6 flag drops", int'(sweep_fall), 0);
    at_tick(4);
    check("R6 reaches zero", int'(core_ofs), 0);
    at_tick(7);
    check("R6 stays zero", int'(core_ofs), 0);
  endtask

  task automatic t_depth_hold;
    start(2'b00, 1'b0, 1'b1);
    at_tick(1);
    depth_sel = 2'b10;
    at_tick(3);
    check("R7 old depth kept", int'(core_ofs), 3 * S0);
    at_tick(7);
    check("R7 old depth on return", int'(core_ofs), S0);
    at_tick(2 * H + 1);
    check("R7 new depth next period", int'(core_ofs), S2);
  endtask

  task automatic t_apic;
    start(2'b01, 1'b0, 1'b0);
    at_tick(2);
    check("R9 apic gated", int'(apic_ofs), 0);
    check("R9 core runs", int'(core_ofs), 2 * S1);
    apic_en = 1'b1;
    @(negedge clk);
    check("R9 apic enabled", int'(apic_ofs), 2 * S1);
    apic_en = 1'b0;
    @(negedge clk);
    check("R9 apic off again", int'(apic_ofs), 0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_profile(2'b00, S0);
    t_profile(2'b01, S1);
    t_profile(2'b10, S2);
    t_reserved();
    t_disabled();
    t_midoff();
    t_depth_hold();
    t_apic();
    finish_run();
  end
endmodule